// File: doc/BRIEF.md
# Five-Port Mesh Packet Router

This block moves packets through one node of a two-dimensional mesh. It has five links of 32-bit words: one toward each of the four neighbours (east, west, north, south) and one to the local core. The first word of a packet is a header. It carries the destination column, the destination row and the number of payload words that follow it. The router resolves the column offset completely before it moves the packet in the row direction. A packet addressed to this node's own coordinates leaves on the local port.

Each input has a small word buffer. Each output has a registered data stage. Each link uses valid/ready handshaking. The first header that wins an output keeps that output until its last payload word has passed, so the words of two packets never interleave on a link. When several headers want the same free output, a rotating-priority arbiter picks one. The node's own coordinates and the buffer depth are parameters.

Top module: `mesh_router`

## Requirements
- R1: Header word layout: payload length in bits [28:24], destination row (Y) in bits [15:8], destination column (X) in bits [7:0]. The length counts the payload words after the header. The header and payload words are forwarded unchanged.
- R2: When the destination X is greater than LOC_X, the packet leaves on port 1 (east). When it is smaller, the packet leaves on port 2 (west). Y is ignored in both cases.
- R3: When the destination X equals LOC_X, a destination Y greater than LOC_Y selects port 3 (north) and a smaller one selects port 4 (south).
- R4: When both destination coordinates equal the node's own coordinates, the packet leaves on port 0 (local).
- R5: Once a header has been forwarded on an output, that output carries only the words of the same packet until all of its payload words have passed.
- R6: When several headers contend for a free output, the grant rotates: an input that has just been served ranks behind every other waiting input.
- R7: Each output presents at most one word per cycle. While out_valid is high and out_ready is low, the word and its valid stay unchanged.
- R8: A word accepted on an input at one clock edge appears on an unblocked output after the next clock edge.
- R9: When an input buffer is full, in_ready for that input goes low. No word is lost or reordered when the downstream link stalls.
- R10: During reset and in the cycle after it, every out_valid is low and every in_ready is high.
- R11: A packet with length 0 is a single header word and leaves its output free for the next packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 5*WORD_W | Input words; port p occupies bits [p*WORD_W +: WORD_W] |
| in_valid | input | 5 | Input word valid, one bit per port |
| in_ready | output | 5 | Input buffer can accept a word, one bit per port |
| out_data | output | 5*WORD_W | Output words; port p occupies bits [p*WORD_W +: WORD_W] |
| out_valid | output | 5 | Output word valid, one bit per port |
| out_ready | input | 5 | Downstream accepts the output word, one bit per port |

## Verification
Every cycle, the assertions check the following: a stalled output keeps its word, the owner of a locked output does not change while the lock lasts, an input never holds two outputs at once, and the links are quiet after reset. Other behaviour shows only in the bench's scenarios. These are the choice of output for each header (X before Y, and the local case), the two-edge latency, the order in which contenders are granted, and the contiguous delivery of two packets that compete for one link. The scenarios also show back-pressure filling a buffer and zero-length packets releasing their link.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;
  localparam int NPORT   = 5;
  localparam int PIDX_W  = 3;
  localparam int LEN_LSB = 24;
  localparam int Y_LSB   = 8;
  localparam int X_LSB   = 0;

  typedef enum logic [PIDX_W-1:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/mrt_in_fifo.sv
module mrt_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wr_data,
  input  logic         wr_valid,
  output logic         wr_ready,
  output logic [W-1:0] head_data,
  output logic         head_valid,
  input  logic         pop
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         full, empty;

  assign empty      = (wr_ptr == rd_ptr);
  assign full       = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign wr_ready   = !full;
  assign head_valid = !empty;
  assign head_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_valid && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_valid && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop && !empty)     rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/mrt_route.sv
module mrt_route
  import mesh_rtr_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int LOC_X   = 2,
  parameter int LOC_Y   = 2
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [PIDX_W-1:0]  port
);
  localparam logic [COORD_W-1:0] HERE_X = COORD_W'(LOC_X);
  localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(LOC_Y);

  port_e sel;

  always_comb begin
    if (dst_x > HERE_X)      sel = P_EAST;
    else if (dst_x < HERE_X) sel = P_WEST;
    else if (dst_y > HERE_Y) sel = P_NORTH;
    else if (dst_y < HERE_Y) sel = P_SOUTH;
    else                     sel = P_LOCAL;
  end

  assign port = sel;
endmodule

// File: rtl/mrt_rr_arb.sv
module mrt_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= IW'(N-1);
    end else begin
      for (int j = 0; j < N; j++) begin
        if (gnt[j]) last <= IW'(j);
      end
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_rtr_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LEN_W      = 5,
  parameter int COORD_W    = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LOC_X      = 2,
  parameter int LOC_Y      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT*WORD_W-1:0] in_data,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT*WORD_W-1:0] out_data,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready
);
  localparam int NP = NPORT;
  localparam int PW = PIDX_W;

  // input side
  logic [WORD_W-1:0] head   [NP];
  logic [NP-1:0]     hv;
  logic [NP-1:0]     pop;
  logic [PW-1:0]     rt     [NP];
  logic [LEN_W-1:0]  hlen   [NP];
  logic [NP-1:0]     in_busy;
  logic [LEN_W-1:0]  in_cnt [NP];

  // output side
  logic [WORD_W-1:0] oq_data [NP];
  logic [NP-1:0]     oq_valid;
  logic [NP-1:0]     slot_ok;
  logic [NP-1:0]     out_lock;
  logic [PW-1:0]     out_own [NP];
  logic [NP-1:0]     req_v   [NP];
  logic [NP-1:0]     gnt_v   [NP];
  logic [NP-1:0]     mv;
  logic [PW-1:0]     src     [NP];

  for (genvar i = 0; i < NP; i++) begin : g_in
    mrt_in_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .wr_data   (in_data[i*WORD_W +: WORD_W]),
      .wr_valid  (in_valid[i]),
      .wr_ready  (in_ready[i]),
      .head_data (head[i]),
      .head_valid(hv[i]),
      .pop       (pop[i])
    );

    mrt_route #(.COORD_W(COORD_W), .LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_route (
      .dst_x(head[i][X_LSB +: COORD_W]),
      .dst_y(head[i][Y_LSB +: COORD_W]),
      .port (rt[i])
    );

    assign hlen[i] = head[i][LEN_LSB +: LEN_W];
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    assign slot_ok[o] = !oq_valid[o] || out_ready[o];

    always_comb begin
      for (int i = 0; i < NP; i++) begin
        req_v[o][i] = hv[i] && !in_busy[i] && (rt[i] == PW'(o)) &&
                      !out_lock[o] && slot_ok[o];
      end
    end

    mrt_rr_arb #(.N(NP)) u_arb (
      .clk(clk),
      .rst(rst),
      .req(req_v[o]),
      .gnt(gnt_v[o])
    );

    assign out_data[o*WORD_W +: WORD_W] = oq_data[o];
    assign out_valid[o]                 = oq_valid[o];
  end

  // select the word each output takes this cycle
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      mv[o]  = 1'b0;
      src[o] = '0;
      if (|gnt_v[o]) begin
        mv[o] = 1'b1;
        for (int i = 0; i < NP; i++) begin
          if (gnt_v[o][i]) src[o] = PW'(i);
        end
      end else if (out_lock[o] && hv[out_own[o]] && slot_ok[o]) begin
        mv[o]  = 1'b1;
        src[o] = out_own[o];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) begin
        if (mv[o] && (src[o] == PW'(i))) pop[i] = 1'b1;
      end
    end
  end

  // per-input packet length tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      in_busy <= '0;
      for (int i = 0; i < NP; i++) in_cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (pop[i]) begin
          if (!in_busy[i]) begin
            in_busy[i] <= (hlen[i] != '0);
            in_cnt[i]  <= hlen[i];
          end else begin
            in_cnt[i] <= in_cnt[i] - LEN_W'(1);
            if (in_cnt[i] == LEN_W'(1)) in_busy[i] <= 1'b0;
          end
        end
      end
    end
  end

  // output registers and locks
  always_ff @(posedge clk) begin
    if (rst) begin
      oq_valid <= '0;
      out_lock <= '0;
      for (int o = 0; o < NP; o++) out_own[o] <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (mv[o])             oq_valid[o] <= 1'b1;
        else if (out_ready[o]) oq_valid[o] <= 1'b0;

        if ((|gnt_v[o]) && (hlen[src[o]] != '0)) begin
          out_lock[o] <= 1'b1;
          out_own[o]  <= src[o];
        end else if (mv[o] && out_lock[o] && (in_cnt[src[o]] == LEN_W'(1))) begin
          out_lock[o] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NP; o++) begin
      if (mv[o]) oq_data[o] <= head[src[o]];
    end
  end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
  import mesh_rtr_pkg::*;
#(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NPORT*W-1:0]   out_data,
  input logic [NPORT-1:0]     out_valid,
  input logic [NPORT-1:0]     out_ready,
  input logic [NPORT-1:0]     in_ready,
  input logic [NPORT-1:0]     out_lock,
  input logic [PIDX_W-1:0]    out_own [NPORT]
);
  logic [NPORT-1:0] own_hit [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        own_hit[i][o] = out_lock[o] && (out_own[o] == PIDX_W'(i));
      end
    end
  end

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_ready == '1));

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*W +: W])));

    p_owner_stable_r5: assert property (@(posedge clk) disable iff (rst)
      out_lock[o] |=> (!out_lock[o] || $stable(out_own[o])));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    p_single_lock_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(own_hit[i]) <= 1);
  end
endmodule

bind mesh_router mesh_router_chk #(.W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_data (out_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .in_ready (in_ready),
  .out_lock (out_lock),
  .out_own  (out_own)
);

// File: tb/mesh_router_tb.sv
module mesh_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0]      drv_data  [NP];
  logic             drv_valid [NP];
  logic [NP*32-1:0] in_data;
  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [NP*32-1:0] out_data;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_data[i*32 +: 32] = drv_data[i];
      in_valid[i]         = drv_valid[i];
    end
  end

  mesh_router #(.LOC_X(2), .LOC_Y(2)) u_dut (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] got     [NP][$];
  int          got_cyc [NP][$];

  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          got[o].push_back(out_data[o*32 +: 32]);
          got_cyc[o].push_back(cyc);
        end
      end
    end
  end

  function automatic logic [31:0] hdr(int dx, int dy, int len, int tag);
    return {3'b000, 5'(len), 8'(tag), 8'(dy), 8'(dx)};
  endfunction

  function automatic logic [31:0] pay(int tag, int k);
    return {8'hA5, 8'(tag), 16'(k)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_got();
    for (int o = 0; o < NP; o++) begin
      got[o].delete();
      got_cyc[o].delete();
    end
  endtask

  task automatic put_word(int p, logic [31:0] w, output int c);
    @(negedge clk);
    drv_valid[p] = 1'b1;
    drv_data[p]  = w;
    c = cyc;
    while (!in_ready[p]) begin
      @(negedge clk);
      c = cyc;
    end
  endtask

  task automatic send_pkt(int p, int dx, int dy, int len, int tag, output int c0);
    int c;
    put_word(p, hdr(dx, dy, len, tag), c0);
    for (int k = 0; k < len; k++) put_word(p, pay(tag, k), c);
    @(negedge clk);
    drv_valid[p] = 1'b0;
  endtask

  int d0, d1, d2;

  task automatic t_reset();
    for (int i = 0; i < NP; i++) begin
      drv_valid[i] = 1'b0;
      drv_data[i]  = '0;
    end
    out_ready = '1;
    rst = 1'b1;
    wait_cyc(3);
    chk(out_valid == '0, "R10 out_valid", 32'(out_valid), 0);
    chk(in_ready == '1, "R10 in_ready", 32'(in_ready), 32'h1f);
    rst = 1'b0;
    wait_cyc(1);
    chk(out_valid == '0, "R10 out_valid after", 32'(out_valid), 0);
  endtask

  task automatic route_case(int dx, int dy, int exp_p, int tag, string req);
    int total;
    clear_got();
    send_pkt(0, dx, dy, 2, tag, d0);
    wait_cyc(8);
    total = 0;
    for (int o = 0; o < NP; o++) total += got[o].size();
    chk(total == 3, req, 32'(total), 3);
    chk(got[exp_p].size() == 3, req, 32'(got[exp_p].size()), 3);
    if (got[exp_p].size() == 3) begin
      chk(got[exp_p][0] == hdr(dx, dy, 2, tag), "R1 header", got[exp_p][0], hdr(dx, dy, 2, tag));
      chk(got[exp_p][2] == pay(tag, 1), "R1 payload", got[exp_p][2], pay(tag, 1));
    end
  endtask

  task automatic t_route();
    route_case(3, 2, 1, 8'h01, "R2 east");
    route_case(3, 0, 1, 8'h02, "R2 east before south");
    route_case(0, 7, 2, 8'h03, "R2 west before north");
    route_case(2, 5, 3, 8'h04, "R3 north");
    route_case(2, 1, 4, 8'h05, "R3 south");
    route_case(2, 2, 0, 8'h06, "R4 local");
  endtask

  task automatic t_latency();
    clear_got();
    send_pkt(1, 2, 2, 0, 8'h11, d0);
    wait_cyc(4);
    chk(got[0].size() == 1, "R8 delivered", 32'(got[0].size()), 1);
    if (got[0].size() == 1)
      chk(got_cyc[0][0] - d0 == 2, "R8 latency", 32'(got_cyc[0][0] - d0), 2);
  endtask

  task automatic t_wormhole();
    logic [7:0] tg0, tg1;
    clear_got();
    fork
      send_pkt(2, 3, 2, 3, 8'h21, d0);
      send_pkt(3, 3, 2, 3, 8'h32, d1);
    join
    wait_cyc(10);
    chk(got[1].size() == 8, "R5 count", 32'(got[1].size()), 8);
    if (got[1].size() == 8) begin
      for (int pk = 0; pk < 2; pk++) begin
        logic [7:0] tg;
        tg = got[1][pk*4][23:16];
        for (int j = 1; j <= 3; j++)
          chk(got[1][pk*4+j] == pay(tg, j-1), "R5 contiguous", got[1][pk*4+j], pay(tg, j-1));
      end
      tg0 = got[1][0][23:16];
      tg1 = got[1][4][23:16];
      chk(tg0 != tg1, "R5 both packets", 32'(tg1), 32'(tg0 ^ 8'hff));
    end
  endtask

  task automatic t_rr();
    clear_got();
    fork
      begin send_pkt(0, 3, 2, 1, 8'h40, d0); send_pkt(0, 3, 2, 1, 8'h41, d0); end
      begin send_pkt(2, 3, 2, 1, 8'h50, d1); send_pkt(2, 3, 2, 1, 8'h51, d1); end
      begin send_pkt(4, 3, 2, 1, 8'h60, d2); send_pkt(4, 3, 2, 1, 8'h61, d2); end
    join
    wait_cyc(12);
    chk(got[1].size() == 12, "R6 count", 32'(got[1].size()), 12);
    if (got[1].size() == 12) begin
      for (int r = 0; r < 2; r++) begin
        logic [3:0] a, b, c;
        a = got[1][r*6][23:20];
        b = got[1][r*6+2][23:20];
        c = got[1][r*6+4][23:20];
        chk(a != b && b != c && a != c, "R6 rotation",
            {20'h0, a, b, c}, 32'h456);
      end
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    clear_got();
    out_ready[1] = 1'b0;
    fork
      send_pkt(0, 3, 2, 6, 8'h70, d0);
      begin
        wait_cyc(14);
        chk(in_ready[0] == 1'b0, "R9 buffer full", 32'(in_ready[0]), 0);
        chk(out_valid[1] == 1'b1, "R7 valid held", 32'(out_valid[1]), 1);
        held = out_data[32 +: 32];
        wait_cyc(3);
        chk(out_data[32 +: 32] == held && out_valid[1], "R7 data stable", out_data[32 +: 32], held);
        out_ready[1] = 1'b1;
      end
    join
    wait_cyc(10);
    chk(got[1].size() == 7, "R9 no loss", 32'(got[1].size()), 7);
    if (got[1].size() == 7) begin
      chk(got[1][0] == hdr(3, 2, 6, 8'h70), "R9 header", got[1][0], hdr(3, 2, 6, 8'h70));
      for (int k = 0; k < 6; k++)
        chk(got[1][k+1] == pay(8'h70, k), "R9 order", got[1][k+1], pay(8'h70, k));
    end
  endtask

  task automatic t_zero_len();
    clear_got();
    send_pkt(0, 3, 2, 0, 8'h80, d0);
    send_pkt(2, 3, 2, 1, 8'h90, d1);
    wait_cyc(8);
    chk(got[1].size() == 3, "R11 count", 32'(got[1].size()), 3);
    if (got[1].size() == 3) begin
      chk(got[1][0] == hdr(3, 2, 0, 8'h80), "R11 first", got[1][0], hdr(3, 2, 0, 8'h80));
      chk(got[1][2] == pay(8'h90, 0), "R11 next packet", got[1][2], pay(8'h90, 0));
    end
  endtask

  initial begin
    t_reset();
    t_route();
    t_latency();
    t_wormhole();
    t_rr();
    t_backpressure();
    t_zero_len();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule